// File: doc/BRIEF.md
# Circular Parity Trace Buffer

This block keeps a short on-chip history of signature parity for silicon debug. It stores the history in a bit-addressed memory of `CAP_BITS` cells. The block has two recording modes. In continuous mode it stores one composite parity bit on every cycle, wraps at the end of the memory and overwrites the oldest bit. When the session stops, the buffer therefore holds the most recent `CAP_BITS` cycles. In triggered mode it waits until a free-running cycle counter reaches a programmed value. From the next cycle on, it stores the whole per-group parity vector (`GROUPS` bits) every cycle. The memory then holds `CAP_BITS / GROUPS` cycles of history.

A halt request from the periodic monitor freezes recording for good. The halt holds until reset. After the halt, the write pointer and the sticky wrap flag stay visible. Software uses them to find the oldest valid entry and to rebuild the time order. The read port then returns one stored entry per request. A read made while recording is still running returns zero and raises an error pulse.

The mode input must be held steady from reset onward.

Top module: `par_trace_buf`

## Requirements
- R1: After reset the write pointer is 0, the wrap flag is 0, read data is 0, the read error is 0, and every memory cell holds 0.
- R2: Continuous mode (mode 0) stores `bit_i` in cell `wr_ptr_o` on every active cycle from the first cycle after reset. The pointer then advances by one.
- R3: When the pointer stands at the last entry and a write occurs, the pointer returns to 0. That write, and the writes after it, overwrite the oldest entries. The wrap flag becomes 1 and stays 1 until reset.
- R4: A cycle with `halt_i` high performs no write, and neither does any later cycle until reset. The pointer, the wrap flag, the stored contents and the cycle counter all stay fixed.
- R5: In triggered mode (mode 1) the cycle counter reads 0 in the first cycle after reset. When it equals `trig_cycle_i` in an unfrozen cycle, writes begin on the following cycle. Before that, nothing is written and the pointer stays at 0.
- R6: In triggered mode each write stores the whole `vec_i` in slot `wr_ptr_o`. Bit g of slot s lives in cell s*GROUPS+g. The slot index wraps at CAP_BITS/GROUPS, with the wrap flag behaving as in R3.
- R7: A read request (`rd_en_i`) made while frozen, including the halt cycle itself, returns data one cycle later. In mode 0 the data is cell `rd_addr_i` in bit 0, with zeros above. In mode 1 it is the slot selected by the low log2(CAP_BITS/GROUPS) address bits.
- R8: A read request made while recording returns zero data and a one-cycle `rd_err_o` pulse. It leaves the memory unchanged. With no request, both read outputs are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = continuous single bit, 1 = triggered vector |
| trig_cycle_i | input | CNT_W | Cycle-counter value that arms triggered mode |
| halt_i | input | 1 | Halt request from the periodic monitor (freezes, sticky) |
| bit_i | input | 1 | Composite parity bit |
| vec_i | input | GROUPS | Per-group parity vector |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read entry index |
| rd_data_o | output | GROUPS | Read data, one cycle after the request |
| rd_err_o | output | 1 | Read attempted while recording |
| wr_ptr_o | output | AW | Next entry to be written |
| wrapped_o | output | 1 | Buffer has wrapped at least once |

## Verification
The bench steers at the seams of the recording window, each checked against a behavioural model on every clock:
- **Wrap.** It runs past the end of the memory more than once. A pointer that saturates instead of wrapping, or a wrap flag that clears, shows up as a wrong pointer or flag, and as stale cells on the dump.
- **Trigger edge.** In triggered mode it places the trigger at cycle 0 and mid-run, and also out of reach. A design that writes in the trigger cycle itself moves the pointer one entry too far.
- **Halt cycle.** It halts and keeps feeding data, and reads in the halt cycle. A design that still writes during or after the halt changes the pointer or the dumped contents.
- **Read addressing.** It reads while recording is live, which must give zeros and an error pulse without disturbing any cell. It also issues slot reads with high address bits set, which catches a decoder that uses the full address.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef enum logic {
    REC_CONT = 1'b0,
    REC_TRIG = 1'b1
  } rec_mode_e;

  // next entry index, wrapping at lim
  function automatic int unsigned ptr_advance(input int unsigned p, input int unsigned lim);
    return (p + 1 >= lim) ? 0 : p + 1;
  endfunction

  // true when p is the last entry before wrapping
  function automatic bit at_last(input int unsigned p, input int unsigned lim);
    return (p + 1 >= lim);
  endfunction

  // first cell of a slot of the given width
  function automatic int unsigned slot_base(input int unsigned slot, input int unsigned width);
    return slot * width;
  endfunction

endpackage

// File: rtl/tpb_ctrl.sv
module tpb_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             halt_i,
  output logic             frozen_o,
  output logic             wr_en_o
);
  import tpb_pkg::*;

  logic [CNT_W-1:0] cyc_q;
  logic             frz_q;
  logic             armed_q;
  logic             trig_hit;
  rec_mode_e        mode;

  assign mode     = rec_mode_e'(mode_i);
  assign frozen_o = frz_q | halt_i;
  assign trig_hit = !frozen_o && (mode == REC_TRIG) && !armed_q && (cyc_q == trig_i);
  assign wr_en_o  = !frozen_o && ((mode == REC_CONT) || armed_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      frz_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      frz_q <= frozen_o;
      if (!frozen_o) cyc_q <= cyc_q + 1'b1;
      if (trig_hit)  armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tpb_ptr.sv
module tpb_ptr #(
  parameter int CAP   = 64,
  parameter int SLOTS = 16,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wr_en_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrapped_o
);
  import tpb_pkg::*;

  logic [AW-1:0] ptr_q;
  logic          wrap_q;
  int unsigned   lim;
  logic          wrap_evt;

  always_comb begin
    lim      = (rec_mode_e'(mode_i) == REC_CONT) ? CAP : SLOTS;
    wrap_evt = wr_en_i && at_last(32'(ptr_q), lim);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (wr_en_i)  ptr_q  <= AW'(ptr_advance(32'(ptr_q), lim));
      if (wrap_evt) wrap_q <= 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign wrapped_o = wrap_q;

endmodule

// File: rtl/tpb_store.sv
module tpb_store #(
  parameter int CAP = 64,
  parameter int G   = 4,
  parameter int AW  = 6,
  parameter int SAW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          bit_i,
  input  logic [G-1:0]  vec_i,
  input  logic          rd_en_i,
  input  logic          rd_ok_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [G-1:0]  rd_data_o,
  output logic          rd_err_o
);
  import tpb_pkg::*;

  logic [CAP-1:0] mem_q;
  logic [CAP-1:0] mem_d;
  logic [G-1:0]   rd_word;
  logic [AW-1:0]  rd_base;
  logic [G-1:0]   rd_data_q;
  logic           rd_err_q;
  logic           cont;

  assign cont = (rec_mode_e'(mode_i) == REC_CONT);

  for (genvar i = 0; i < CAP; i++) begin : g_cell
    localparam int SLOT = i / G;
    localparam int LANE = i % G;
    logic hit;
    assign hit      = wr_en_i && (cont ? (ptr_i == AW'(i)) : (ptr_i == AW'(SLOT)));
    assign mem_d[i] = hit ? (cont ? bit_i : vec_i[LANE]) : mem_q[i];
  end

  always_comb begin
    rd_base = AW'(slot_base(32'(rd_addr_i[SAW-1:0]), G));
    rd_word = '0;
    if (cont) rd_word[0] = mem_q[rd_addr_i];
    else      rd_word    = mem_q[rd_base +: G];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_q     <= '0;
      rd_data_q <= '0;
      rd_err_q  <= 1'b0;
    end else begin
      mem_q     <= mem_d;
      rd_data_q <= (rd_en_i && rd_ok_i) ? rd_word : '0;
      rd_err_q  <= rd_en_i && !rd_ok_i;
    end
  end

  assign rd_data_o = rd_data_q;
  assign rd_err_o  = rd_err_q;

endmodule

// File: rtl/par_trace_buf.sv
module par_trace_buf #(
  parameter int CAP_BITS = 64,
  parameter int GROUPS   = 4,
  parameter int CNT_W    = 16,
  localparam int SLOTS   = CAP_BITS / GROUPS,
  localparam int AW      = $clog2(CAP_BITS),
  localparam int SAW     = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  trig_cycle_i,
  input  logic              halt_i,
  input  logic              bit_i,
  input  logic [GROUPS-1:0] vec_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [GROUPS-1:0] rd_data_o,
  output logic              rd_err_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              wrapped_o
);

  // internal events, also observed by the checker
  logic frozen;
  logic wr_en;

  tpb_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .trig_i   (trig_cycle_i),
    .halt_i   (halt_i),
    .frozen_o (frozen),
    .wr_en_o  (wr_en)
  );

  tpb_ptr #(.CAP(CAP_BITS), .SLOTS(SLOTS), .AW(AW)) ptr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .wr_en_i   (wr_en),
    .ptr_o     (wr_ptr_o),
    .wrapped_o (wrapped_o)
  );

  tpb_store #(.CAP(CAP_BITS), .G(GROUPS), .AW(AW), .SAW(SAW)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .wr_en_i   (wr_en),
    .ptr_i     (wr_ptr_o),
    .bit_i     (bit_i),
    .vec_i     (vec_i),
    .rd_en_i   (rd_en_i),
    .rd_ok_i   (frozen),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .rd_err_o  (rd_err_o)
  );

endmodule

// File: rtl/par_trace_buf_chk.sv
module par_trace_buf_chk #(
  parameter int SLOTS = 16,
  parameter int AW    = 6,
  parameter int G     = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_i,
  input logic          halt_i,
  input logic          frozen,
  input logic          wr_en,
  input logic          rd_en_i,
  input logic [G-1:0]  rd_data_o,
  input logic          rd_err_o,
  input logic [AW-1:0] wr_ptr_o,
  input logic          wrapped_o
);

  // R4
  freeze_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> frozen);

  // R4
  frozen_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> $stable(wr_ptr_o));

  // R4
  halt_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> frozen && !wr_en);

  // R2
  idle_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(wr_ptr_o));

  // R2
  write_moves_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !$stable(wr_ptr_o));

  // R3
  wrap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |=> wrapped_o);

  // R5
  trig_keeps_going_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && wr_en) |=> (wr_en || frozen));

  // R6
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> (32'(wr_ptr_o) < SLOTS));

  // R8
  live_read_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !frozen) |=> (rd_err_o && rd_data_o == '0));

  // R8
  err_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> $past(rd_en_i));

  // R8
  no_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_err_o && rd_data_o == '0));

endmodule

bind par_trace_buf par_trace_buf_chk #(.SLOTS(SLOTS), .AW(AW), .G(GROUPS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .halt_i    (halt_i),
  .frozen    (frozen),
  .wr_en     (wr_en),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .rd_err_o  (rd_err_o),
  .wr_ptr_o  (wr_ptr_o),
  .wrapped_o (wrapped_o)
);

// File: tb/par_trace_buf_tb_top.sv
`timescale 1ns/1ps
module par_trace_buf_tb_top;
  localparam int CAP   = 64;
  localparam int G     = 4;
  localparam int CW    = 16;
  localparam int SLOTS = CAP / G;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode;
  logic [CW-1:0] trig;
  logic          halt;
  logic          pbit;
  logic [G-1:0]  pvec;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [G-1:0]  rd_data;
  logic          rd_err;
  logic [AW-1:0] wr_ptr;
  logic          wrapped;

  always #4 clk = ~clk;

  par_trace_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .trig_cycle_i(trig),
    .halt_i(halt), .bit_i(pbit), .vec_i(pvec), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_err_o(rd_err),
    .wr_ptr_o(wr_ptr), .wrapped_o(wrapped)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference
  bit rmem[CAP];
  int m_cyc, m_ptr, m_rd;
  bit m_frz, m_arm, m_wrap, m_err;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (rmem[i]) rmem[i] = 1'b0;
    m_cyc = 0; m_ptr = 0; m_rd = 0;
    m_frz = 0; m_arm = 0; m_wrap = 0; m_err = 0;
  endtask

  task automatic model_step();
    bit fz;
    bit wr;
    fz = m_frz || halt;
    m_rd = 0; m_err = 0;
    if (rd_en) begin
      if (fz) begin
        if (mode == 1'b0) m_rd = int'(rmem[rd_addr]);
        else for (int g = 0; g < G; g++)
          m_rd += int'(rmem[(int'(rd_addr) % SLOTS) * G + g]) << g;
      end else m_err = 1;
    end
    wr = !fz && (mode == 1'b0 || m_arm);
    if (wr) begin
      if (mode == 1'b0) begin
        rmem[m_ptr] = pbit;
        m_ptr = (m_ptr + 1) % CAP;
      end else begin
        for (int g = 0; g < G; g++) rmem[m_ptr * G + g] = pvec[g];
        m_ptr = (m_ptr + 1) % SLOTS;
      end
      if (m_ptr == 0) m_wrap = 1;
    end
    if (!fz && mode == 1'b1 && m_cyc == int'(trig)) m_arm = 1;
    if (!fz) m_cyc++;
    m_frz = fz;
  endtask

  task automatic compare_all();
    chk(mode ? "R6 pointer" : "R2 pointer", int'(wr_ptr), m_ptr);
    chk("R3 wrap flag", int'(wrapped), int'(m_wrap));
    chk("R7 read data", int'(rd_data), m_rd);
    chk("R8 read error", int'(rd_err), int'(m_err));
  endtask

  task automatic step(input logic b, input logic [G-1:0] v, input logic h,
                      input logic re, input logic [AW-1:0] ra);
    pbit = b; pvec = v; halt = h; rd_en = re; rd_addr = ra;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input logic md, input int tv);
    rst_n = 1'b0; mode = md; trig = CW'(tv);
    pbit = 0; pvec = '0; halt = 0; rd_en = 0; rd_addr = '0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    // R1: reset values seen at the ports
    chk("R1 pointer", int'(wr_ptr), 0);
    chk("R1 wrap", int'(wrapped), 0);
    chk("R1 rdata", int'(rd_data), 0);
    chk("R1 rerr", int'(rd_err), 0);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++)
      step(1'($urandom), G'($urandom), 1'b0, 1'b0, '0);
  endtask

  task automatic dump(input int n);
    for (int a = 0; a < n; a++) step(1'($urandom), G'($urandom), 1'b0, 1'b1, AW'(a));
    step(0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    // R1: memory zero after reset
    do_reset(1'b0, 0);
    step(1, '1, 1'b1, 1'b0, '0);
    dump(CAP);

    // R2 / R8: short continuous run with a live read
    do_reset(1'b0, 0);
    run(20);
    step(1, '0, 1'b0, 1'b1, AW'(3));
    chk("R8 err pulse", int'(rd_err), 1);
    run(19);
    chk("R2 ptr after 40", int'(wr_ptr), 40);
    chk("R3 no wrap yet", int'(wrapped), 0);
    step(1, '0, 1'b1, 1'b1, AW'(5));
    chk("R7 read in halt cycle err", int'(rd_err), 0);
    dump(CAP);

    // R3 / R4: wrap twice, halt, keep feeding
    do_reset(1'b0, 0);
    run(150);
    chk("R3 ptr 150", int'(wr_ptr), 150 % CAP);
    chk("R3 wrapped", int'(wrapped), 1);
    step(1, '1, 1'b1, 1'b0, '0);
    run(10);
    chk("R4 ptr held", int'(wr_ptr), 150 % CAP);
    dump(CAP);

    // R5: trigger at 20, writes from 21
    do_reset(1'b1, 20);
    run(20);
    chk("R5 nothing before trigger", int'(wr_ptr), 0);
    run(10);
    chk("R5 ptr after trigger", int'(wr_ptr), 9);
    step(0, '0, 1'b1, 1'b0, '0);
    dump(SLOTS);
    // R7: high address bits ignored in slot mode
    step(0, '0, 1'b0, 1'b1, AW'(SLOTS + 3));
    step(0, '0, 1'b0, 1'b0, '0);

    // R6: trigger at 0, wrap slots
    do_reset(1'b1, 0);
    run(50);
    chk("R6 slot ptr", int'(wr_ptr), 49 % SLOTS);
    chk("R6 wrapped", int'(wrapped), 1);
    step(0, '0, 1'b1, 1'b0, '0);
    dump(SLOTS);

    // R5: trigger out of reach, halt stops counter too
    do_reset(1'b1, 500);
    run(100);
    step(0, '0, 1'b1, 1'b0, '0);
    run(600);
    chk("R5 never armed", int'(wr_ptr), 0);
    chk("R4 no wrap", int'(wrapped), 0);

    // R5: halt in the trigger cycle keeps it from arming
    do_reset(1'b1, 0);
    step(1, '1, 1'b1, 1'b0, '0);
    run(5);
    chk("R5 halted at trigger", int'(wr_ptr), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule